// File: doc/BRIEF.md
# Multi-Operand Compressor Tree Adder

This block adds N unsigned operands of W bits each, purely combinationally, and returns their sum modulo 2^W. The operands are first reduced level by level with word-wide carry-save compressors. Each compressor keeps the arithmetic total of its inputs and emits a sum vector and a carry vector. Reduction stops when at most two vectors remain. A single carry-propagate adder then merges those two vectors into the result.

Two elaboration-time options shape the structure, and neither changes the result. The reduction strategy either uses only 3:2 compressors or takes 4:2 compressors greedily. The final adder is a ripple-carry chain, a logarithmic-depth prefix network, or an automatic pick that depends on the width. The block sits inside larger arithmetic datapaths such as multiplier partial-product summation, accumulation of several terms, or checksum folding. Any pipelining is the surrounding logic's job.

Top module: `ctree_sum`

## Requirements
- R1: For every input combination, `sum_o` equals the sum of all N operands reduced modulo 2^W.
- R2: A 3:2 compressor returns a sum vector (bitwise XOR of its three inputs) and a carry vector (bitwise majority shifted up one bit, zero in bit 0, top carry dropped), whose total modulo 2^W equals the total of the inputs.
- R3: A 4:2 compressor chains two 3:2 rows: the first takes inputs a, b and c, and the second takes the first row's sum, input d and the first row's shifted carries. Its two outputs total a+b+c+d modulo 2^W.
- R4: At each level the vectors are grouped in order. The full-adder-only strategy uses only 3:2 groups. The greedy strategy takes 4:2 groups while four or more vectors remain, then one 3:2 group if exactly three remain. One or two leftover vectors pass to the next level unchanged. Both strategies yield the same sum.
- R5: With N = 1 the output equals the single operand exactly.
- R6: The final adder is a ripple chain or a prefix network of ceil(log2 W) generate/propagate stages. In automatic mode, W < 16 selects ripple and W >= 16 selects prefix. Every choice gives the same sum.
- R7: Carries out of bit W-1 are discarded at every stage. For example, N all-ones operands give (2^W - N) mod 2^W.
- R8: The degenerate width W = 1 is supported. The output is then the parity of the operand bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ops_i | input | N*W | Packed array of N unsigned operands; operand k sits in bits [k*W +: W] |
| sum_o | output | W | Sum of all operands modulo 2^W |

## Verification
The bench concentrates on wrap-around and on operand counts that leave one or two vectors uncompressed at a level. It uses all-ones operands, walking ones across every bit and long random runs. A compressor that misplaced its carry shift would be off by a multiple of a power of two. One that kept the top carry would disturb the wrap cases. A schedule that dropped a leftover vector would lose a whole operand for counts such as 5, 7 and 9. The threshold width of exactly 16, a width of 64, a single operand and a 1-bit width are each instantiated. A wrong prefix span would show up as missing carries over long propagate runs, and a bad width corner would show up as a wrong parity or a truncated result.

// File: rtl/ctree_pkg.sv
package ctree_pkg;

   typedef enum logic [0:0] {
      ST_FA_ONLY  = 1'b0,
      ST_GREEDY42 = 1'b1
   } strat_e;

   typedef enum logic [1:0] {
      FIN_AUTO   = 2'd0,
      FIN_RIPPLE = 2'd1,
      FIN_PREFIX = 2'd2
   } final_e;

   localparam int PREFIX_MIN_W = 16;

   // vector count after one reduction level
   function automatic int next_cnt(int k, strat_e st);
      int n4, r, n3;
      n4 = (st == ST_GREEDY42) ? k / 4 : 0;
      r  = k - 4 * n4;
      n3 = (st == ST_GREEDY42) ? ((r >= 3) ? 1 : 0) : r / 3;
      return 2 * n4 + 2 * n3 + (r - 3 * n3);
   endfunction

   function automatic int cnt_at(int n, strat_e st, int lvl);
      int k;
      k = n;
      for (int i = 0; i < lvl; i++)
         if (k > 2) k = next_cnt(k, st);
      return k;
   endfunction

   function automatic int num_levels(int n, strat_e st);
      int k, l;
      k = n;
      l = 0;
      while (k > 2) begin
         k = next_cnt(k, st);
         l++;
      end
      return l;
   endfunction

   function automatic bit use_prefix(int w, final_e fm);
      return (fm == FIN_PREFIX) || ((fm == FIN_AUTO) && (w >= PREFIX_MIN_W));
   endfunction

endpackage

// File: rtl/ctree_csa32.sv
module ctree_csa32 #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] c_i,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] carry_o
);

   assign sum_o = a_i ^ b_i ^ c_i;

   if (W > 1) begin : g_wide
      logic [W-2:0] maj;
      assign maj = (a_i[W-2:0] & b_i[W-2:0]) |
                   (a_i[W-2:0] & c_i[W-2:0]) |
                   (b_i[W-2:0] & c_i[W-2:0]);
      assign carry_o = {maj, 1'b0};
   end else begin : g_bit
      assign carry_o = 1'b0;
   end

   always_comb begin
      assert_csa32_total_R2: assert ((sum_o + carry_o) == (a_i + b_i + c_i))
         else $error("3:2 compressor lost value");
   end

endmodule

// File: rtl/ctree_csa42.sv
module ctree_csa42 #(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  logic [W-1:0] c_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] carry_o
);

   logic [W-1:0] row_s, row_c;

   ctree_csa32 #(.W(W)) u_row0 (
      .a_i(a_i), .b_i(b_i), .c_i(c_i), .sum_o(row_s), .carry_o(row_c)
   );

   ctree_csa32 #(.W(W)) u_row1 (
      .a_i(row_s), .b_i(d_i), .c_i(row_c), .sum_o(sum_o), .carry_o(carry_o)
   );

   always_comb begin
      assert_csa42_total_R3: assert ((sum_o + carry_o) == (a_i + b_i + c_i + d_i))
         else $error("4:2 compressor lost value");
   end

endmodule

// File: rtl/ctree_cpa.sv
module ctree_cpa #(
   parameter int W          = 8,
   parameter bit USE_PREFIX = 1'b0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] sum_o
);

   logic [W-1:0] cy;
   assign cy[0] = 1'b0;

   if (USE_PREFIX) begin : g_prefix
      localparam int STG = (W > 1) ? $clog2(W) : 0;
      logic [STG:0][W-1:0] gs, ps;

      assign gs[0] = a_i & b_i;
      assign ps[0] = a_i ^ b_i;

      for (genvar s = 1; s <= STG; s++) begin : g_stage
         localparam int D = 1 << (s - 1);
         for (genvar i = 0; i < W; i++) begin : g_bit
            if (i >= D) begin : g_comb
               assign gs[s][i] = gs[s-1][i] | (ps[s-1][i] & gs[s-1][i-D]);
               assign ps[s][i] = ps[s-1][i] & ps[s-1][i-D];
            end else begin : g_pass
               assign gs[s][i] = gs[s-1][i];
               assign ps[s][i] = ps[s-1][i];
            end
         end
      end

      for (genvar i = 1; i < W; i++) begin : g_cy
         assign cy[i] = gs[STG][i-1];
      end
      assign sum_o = ps[0] ^ cy;

      // the top stage spans bits 0..i: a fully propagating span cannot generate
      always_comb begin
         for (int i = 0; i < W; i++) begin
            assert_prefix_span_R6: assert (!(ps[STG][i] && gs[STG][i]))
               else $error("prefix span inconsistent at bit %0d", i);
         end
      end
   end else begin : g_ripple
      for (genvar i = 0; i < W - 1; i++) begin : g_cy
         assign cy[i+1] = (a_i[i] & b_i[i]) | (a_i[i] & cy[i]) | (b_i[i] & cy[i]);
      end
      assign sum_o = a_i ^ b_i ^ cy;
   end

   always_comb begin
      assert_cpa_sum_R6: assert (sum_o == a_i + b_i)
         else $error("final adder mismatch");
   end

endmodule

// File: rtl/ctree_sum.sv
module ctree_sum #(
   parameter int                N          = 9,
   parameter int                W          = 16,
   parameter ctree_pkg::strat_e STRATEGY   = ctree_pkg::ST_GREEDY42,
   parameter ctree_pkg::final_e FINAL_MODE = ctree_pkg::FIN_AUTO
) (
   input  logic [N-1:0][W-1:0] ops_i,
   output logic [W-1:0]        sum_o
);

   localparam int  LEVELS = ctree_pkg::num_levels(N, STRATEGY);
   localparam int  KF     = ctree_pkg::cnt_at(N, STRATEGY, LEVELS);
   localparam bit  PFX    = ctree_pkg::use_prefix(W, FINAL_MODE);

   if (N < 1 || N > 16) begin : g_bad_n
      $error("ctree_sum: N must lie in 1..16");
   end
   if (W < 1 || W > 64) begin : g_bad_w
      $error("ctree_sum: W must lie in 1..64");
   end

   for (genvar l = 0; l <= LEVELS; l++) begin : g_lv
      localparam int K = ctree_pkg::cnt_at(N, STRATEGY, l);
      logic [K-1:0][W-1:0] v;

      if (l == 0) begin : g_in
         assign v = ops_i;
      end else begin : g_red
         localparam int KP = ctree_pkg::cnt_at(N, STRATEGY, l - 1);
         localparam int N4 = (STRATEGY == ctree_pkg::ST_GREEDY42) ? KP / 4 : 0;
         localparam int RM = KP - 4 * N4;
         localparam int N3 = (STRATEGY == ctree_pkg::ST_GREEDY42) ?
                             ((RM >= 3) ? 1 : 0) : RM / 3;
         localparam int NP = RM - 3 * N3;

         if (K != 2 * N4 + 2 * N3 + NP) begin : g_bad_sched
            $error("ctree_sum: inconsistent level schedule");
         end

         for (genvar g = 0; g < N4; g++) begin : g_c42
            ctree_csa42 #(.W(W)) u_c42 (
               .a_i    (g_lv[l-1].v[4*g+0]),
               .b_i    (g_lv[l-1].v[4*g+1]),
               .c_i    (g_lv[l-1].v[4*g+2]),
               .d_i    (g_lv[l-1].v[4*g+3]),
               .sum_o  (v[2*g]),
               .carry_o(v[2*g+1])
            );
         end

         for (genvar g = 0; g < N3; g++) begin : g_c32
            ctree_csa32 #(.W(W)) u_c32 (
               .a_i    (g_lv[l-1].v[4*N4+3*g+0]),
               .b_i    (g_lv[l-1].v[4*N4+3*g+1]),
               .c_i    (g_lv[l-1].v[4*N4+3*g+2]),
               .sum_o  (v[2*N4+2*g]),
               .carry_o(v[2*N4+2*g+1])
            );
         end

         for (genvar g = 0; g < NP; g++) begin : g_pass
            assign v[2*N4+2*N3+g] = g_lv[l-1].v[4*N4+3*N3+g];
         end
      end
   end

   logic [W-1:0] fin_a, fin_b;
   assign fin_a = g_lv[LEVELS].v[0];

   if (KF >= 2) begin : g_two
      assign fin_b = g_lv[LEVELS].v[1];
   end else begin : g_one
      assign fin_b = '0;
   end

   ctree_cpa #(.W(W), .USE_PREFIX(PFX)) u_cpa (
      .a_i  (fin_a),
      .b_i  (fin_b),
      .sum_o(sum_o)
   );

   logic [W-1:0] chk_sum;
   always_comb begin
      chk_sum = '0;
      for (int i = 0; i < N; i++) chk_sum = chk_sum + ops_i[i];
      assert_total_R1: assert (sum_o == chk_sum)
         else $error("tree total mismatch");
      if (N == 1) begin
         assert_single_R5: assert (sum_o == ops_i[0])
            else $error("single operand not passed through");
      end
   end

endmodule

// File: tb/sim_ctree_sum.sv
`timescale 1ns/1ps
module sim_ctree_sum;
   import ctree_pkg::*;

   localparam int NI = 8;
   localparam int CN [NI] = '{9, 7, 5, 3, 4, 2, 1, 16};
   localparam int CW [NI] = '{12, 20, 16, 8, 64, 33, 10, 1};
   // requirement each instance mainly targets
   localparam string TAG [NI] = '{"R1", "R4", "R6", "R2", "R3", "R7", "R5", "R8"};

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [15:0][63:0] pool = '0;

   logic [8:0][11:0]  op0;  logic [11:0] s0;
   logic [6:0][19:0]  op1;  logic [19:0] s1;
   logic [4:0][15:0]  op2;  logic [15:0] s2;
   logic [2:0][7:0]   op3;  logic [7:0]  s3;
   logic [3:0][63:0]  op4;  logic [63:0] s4;
   logic [1:0][32:0]  op5;  logic [32:0] s5;
   logic [0:0][9:0]   op6;  logic [9:0]  s6;
   logic [15:0][0:0]  op7;  logic [0:0]  s7;

   always_comb begin
      for (int i = 0; i < 9;  i++) op0[i] = pool[i][11:0];
      for (int i = 0; i < 7;  i++) op1[i] = pool[i][19:0];
      for (int i = 0; i < 5;  i++) op2[i] = pool[i][15:0];
      for (int i = 0; i < 3;  i++) op3[i] = pool[i][7:0];
      for (int i = 0; i < 4;  i++) op4[i] = pool[i];
      for (int i = 0; i < 2;  i++) op5[i] = pool[i][32:0];
      op6[0] = pool[0][9:0];
      for (int i = 0; i < 16; i++) op7[i] = pool[i][0:0];
   end

   ctree_sum #(.N(9),  .W(12), .STRATEGY(ST_GREEDY42), .FINAL_MODE(FIN_AUTO))   u0 (.ops_i(op0), .sum_o(s0));
   ctree_sum #(.N(7),  .W(20), .STRATEGY(ST_FA_ONLY),  .FINAL_MODE(FIN_AUTO))   u1 (.ops_i(op1), .sum_o(s1));
   ctree_sum #(.N(5),  .W(16), .STRATEGY(ST_GREEDY42), .FINAL_MODE(FIN_AUTO))   u2 (.ops_i(op2), .sum_o(s2));
   ctree_sum #(.N(3),  .W(8),  .STRATEGY(ST_FA_ONLY),  .FINAL_MODE(FIN_RIPPLE)) u3 (.ops_i(op3), .sum_o(s3));
   ctree_sum #(.N(4),  .W(64), .STRATEGY(ST_GREEDY42), .FINAL_MODE(FIN_PREFIX)) u4 (.ops_i(op4), .sum_o(s4));
   ctree_sum #(.N(2),  .W(33), .STRATEGY(ST_GREEDY42), .FINAL_MODE(FIN_RIPPLE)) u5 (.ops_i(op5), .sum_o(s5));
   ctree_sum #(.N(1),  .W(10), .STRATEGY(ST_GREEDY42), .FINAL_MODE(FIN_AUTO))   u6 (.ops_i(op6), .sum_o(s6));
   ctree_sum #(.N(16), .W(1),  .STRATEGY(ST_FA_ONLY),  .FINAL_MODE(FIN_AUTO))   u7 (.ops_i(op7), .sum_o(s7));

   typedef logic [NI-1:0][63:0] exp_t;
   exp_t sb_q [$];
   int checks = 0;
   int fails  = 0;
   bit drv_done = 1'b0;
   bit finished = 1'b0;

   function automatic logic [63:0] wmask(int w);
      return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
   endfunction

   function automatic logic [63:0] ref_sum(int n, int w);
      logic [63:0] acc;
      acc = '0;
      for (int i = 0; i < n; i++) acc = acc + (pool[i] & wmask(w));
      return acc & wmask(w);
   endfunction

   task automatic drive(input logic [15:0][63:0] v);
      exp_t e;
      @(posedge clk);
      pool = v;
      for (int k = 0; k < NI; k++) e[k] = ref_sum(CN[k], CW[k]);
      sb_q.push_back(e);
   endtask

   function automatic logic [63:0] act(int k);
      case (k)
         0: return 64'(s0);
         1: return 64'(s1);
         2: return 64'(s2);
         3: return 64'(s3);
         4: return s4;
         5: return 64'(s5);
         6: return 64'(s6);
         default: return 64'(s7);
      endcase
   endfunction

   // monitor: compares on the falling edge, after inputs settled
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         for (int k = 0; k < NI; k++) begin
            checks++;
            if (act(k) !== e[k]) begin
               fails++;
               $display("FAIL %s u%0d N=%0d W=%0d: actual=%h expected=%h",
                        TAG[k], k, CN[k], CW[k], act(k), e[k]);
            end
         end
      end
   end

   initial begin
      logic [15:0][63:0] v;
      // R1 zero operands give zero (idle state)
      drive('0);
      // R7 all-ones wraps: each instance expects (2^W - N) mod 2^W
      drive({16{64'hFFFF_FFFF_FFFF_FFFF}});
      // R2/R3 walking one in every operand, every bit position
      for (int b = 0; b < 64; b++) begin
         for (int i = 0; i < 16; i++) v[i] = 64'd1 << ((b + i) % 64);
         drive(v);
      end
      // R7 long carry chains: ones plus a single one in operand 0
      for (int i = 0; i < 16; i++) v[i] = (i == 0) ? 64'd1 : '1;
      drive(v);
      // R4/R6 random patterns reach every level and both adder kinds
      for (int t = 0; t < 400; t++) begin
         for (int i = 0; i < 16; i++) v[i] = {$urandom(), $urandom()};
         drive(v);
      end
      // R5/R8 sparse patterns: only operand 0 set, then odd parity counts
      for (int t = 0; t < 20; t++) begin
         v = '0;
         v[0] = {$urandom(), $urandom()};
         for (int i = 0; i < t % 16; i++) v[i + 1] = 64'd1;
         drive(v);
      end
      @(posedge clk);
      @(posedge clk);
      drv_done = 1'b1;
   end

   initial begin
      wait (drv_done && sb_q.size() == 0);
      @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(5.0 * 20000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule